// File: doc/BRIEF.md
# Indexed Command-Object Flash Launcher

This block is the register front end of a data-flash controller. Software does not issue a command with one register write. It builds a small command object word by word. It first writes a pointer register to pick a slot. It then writes a 16-bit word through a data window into that slot. Slot 0 carries the operation code in its upper byte and the top eight address bits in its lower byte. Slot 1 carries the low sixteen address bits. Slot 2 carries the word to be programmed.

Software starts the command by writing 1 to the completion bit of the status register, which clears that bit. The block then checks the object. It looks at the divider setting, the operation code, the number of slots written since the last launch, and whether the address falls inside the data-flash window (32 sectors of 256 bytes). If every check passes, the block issues a one-cycle sector-erase or word-program request to the array. It then holds the command object locked until the array signals completion. If a check fails, the block raises an error flag and the array is never started. Software reads the flags after every command to learn whether it succeeded.

Top module: `idx_flash_launcher`

## Requirements
- R1: After reset the status register (select 3) reads 0x0080, with completion bit 7 set and error bits clear. The pointer reads 0, and no array request is active.
- R2: The pointer register (select 1) takes the low 3 bits of the written word. Any value above 2, the last slot, is stored and read back as 2.
- R3: A write to the data window (select 2) stores the word in the slot the pointer selects. A read of the data window returns that slot.
- R4: Writing status with bit 7 set, while idle and error-free, launches the command. A valid command gives a single-cycle `arr_start` on the next edge. The request carries the erase/program choice, the address and the data taken from the object, and status then reads 0x0000.
- R5: From launch until the array signals completion, writes to the data window leave every slot unchanged.
- R6: The cycle after `arr_done` is seen while busy, completion bit 7 reads 1 again.
- R7: While the clock-divider register (select 0) holds zero, a launch sets the access-error flag (status bit 5) and starts nothing.
- R8: An operation code other than 0x40 (sector erase) or 0x20 (word program) sets the access-error flag and starts nothing.
- R9: A command whose address is below the window base 0x004000, or at or above base plus 8192, sets the protection flag (status bit 4) and starts nothing.
- R10: Writing 1 to an error bit clears it. A launch attempt while either error flag is set is ignored: no request is issued, the flags keep their value, and the written-slot record is kept.
- R11: Erase needs slots 0 and 1 written since the last processed launch, and program needs slots 0, 1 and 2. Otherwise the launch sets the access-error flag. Every processed launch forgets which slots were written.
- R12: With the sector-align option on (the default), an erase request's address has its low 8 bits forced to zero. A program request passes the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divider, 1 pointer, 2 data window, 3 status |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 16 | Combinational read data |
| arr_start | output | 1 | One-cycle request to the array |
| arr_erase | output | 1 | 1 = sector erase, 0 = word program |
| arr_addr | output | 24 | Byte address of the request |
| arr_wdata | output | 16 | Word to program |
| arr_done | input | 1 | Array completion pulse |
| arr_div | output | DIV_W | Divider value passed to the array timing |

## Verification
The assertions watch several properties on every cycle. A request pulse lasts exactly one cycle and occurs only while busy. Slots never change while locked. The pointer never goes past slot 2. Every issued request lies inside the data-flash window. The busy state ends the cycle after completion. Other behaviour depends on a sequence of register writes and can only be shown by the bench scenarios. These are the error flag chosen for each faulty command, the ignored launch while an error is pending, the forgotten slot record after a launch, and the exact address and data each request carries.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
   typedef enum logic [1:0] {
      REG_DIV  = 2'd0,
      REG_IDX  = 2'd1,
      REG_DATA = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   localparam int          NUM_SLOTS = 3;
   localparam int          ADDR_W    = 24;
   localparam logic [7:0]  OP_PROG   = 8'h20;
   localparam logic [7:0]  OP_ERASE  = 8'h40;
   localparam int          ST_DONE   = 7;
   localparam int          ST_ACC    = 5;
   localparam int          ST_PROT   = 4;

   typedef struct packed {
      logic              erase;
      logic [ADDR_W-1:0] addr;
      logic [15:0]       wdata;
   } arr_req_t;
endpackage

// File: rtl/cmd_obj_file.sv
module cmd_obj_file
   import fcl_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          idx_we,
   input  logic                          data_we,
   input  logic [15:0]                   wdata,
   input  logic                          lock,
   input  logic                          clr_mask,
   output logic [IDX_W-1:0]              idx_q,
   output logic [NUM_SLOTS-1:0][15:0]    obj_q,
   output logic [NUM_SLOTS-1:0]          mask_q
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

   logic [IDX_W-1:0] idx_in;
   assign idx_in = wdata[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= (idx_in > LAST) ? LAST : idx_in;
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic hit;
      assign hit = data_we && !lock && (idx_q == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            obj_q[g]  <= '0;
            mask_q[g] <= 1'b0;
         end else begin
            if (hit)           obj_q[g]  <= wdata;
            if (clr_mask)      mask_q[g] <= 1'b0;
            else if (hit)      mask_q[g] <= 1'b1;
         end
      end
   end

   p_idx_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);
   p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(obj_q));
endmodule

// File: rtl/cmd_check.sv
module cmd_check
   import fcl_pkg::*;
#(
   parameter int              SECT_BYTES  = 256,
   parameter int              SECT_COUNT  = 32,
   parameter logic [23:0]     DF_BASE     = 24'h004000,
   parameter bit              ALIGN_ERASE = 1'b1
) (
   input  logic [NUM_SLOTS-1:0][15:0] obj,
   input  logic [NUM_SLOTS-1:0]       mask,
   input  logic                       div_ok,
   output logic                       acc_e,
   output logic                       prot_e,
   output arr_req_t                   req
);
   localparam int SB_W     = $clog2(SECT_BYTES);
   localparam int DF_BYTES = SECT_BYTES * SECT_COUNT;
   localparam logic [ADDR_W:0] LIMIT = {1'b0, DF_BASE} + (ADDR_W+1)'(DF_BYTES);

   logic [7:0]           code;
   logic [ADDR_W-1:0]    addr;
   logic                 is_prog, is_erase, known, in_range;
   logic [NUM_SLOTS-1:0] need;

   assign code     = obj[0][15:8];
   assign addr     = {obj[0][7:0], obj[1]};
   assign is_prog  = (code == OP_PROG);
   assign is_erase = (code == OP_ERASE);
   assign known    = is_prog | is_erase;
   assign need     = is_prog ? 3'b111 : (is_erase ? 3'b011 : 3'b000);
   assign in_range = (addr >= DF_BASE) && ({1'b0, addr} < LIMIT);

   assign acc_e  = !div_ok || !known || ((mask & need) != need);
   assign prot_e = !acc_e && !in_range;

   assign req.erase = is_erase;
   assign req.wdata = obj[2];
   if (ALIGN_ERASE) begin : g_align
      assign req.addr = is_erase ? {addr[ADDR_W-1:SB_W], SB_W'(0)} : addr;
   end else begin : g_raw
      assign req.addr = addr;
   end
endmodule

// File: rtl/launch_ctrl.sv
module launch_ctrl
   import fcl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stat_we,
   input  logic [15:0] wdata,
   input  logic        acc_e,
   input  logic        prot_e,
   input  arr_req_t    req,
   input  logic        arr_done,
   output logic        busy,
   output logic        acc_q,
   output logic        prot_q,
   output logic        clr_mask,
   output logic        arr_start,
   output arr_req_t    req_q
);
   logic launch_try, accept;

   assign launch_try = stat_we && wdata[ST_DONE] && !busy && !acc_q && !prot_q;
   assign accept     = launch_try && !acc_e && !prot_e;
   assign clr_mask   = launch_try;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         acc_q     <= 1'b0;
         prot_q    <= 1'b0;
         arr_start <= 1'b0;
         req_q     <= '0;
      end else begin
         arr_start <= accept;
         if (accept) begin
            busy  <= 1'b1;
            req_q <= req;
         end else if (busy && arr_done) begin
            busy <= 1'b0;
         end
         if (launch_try && acc_e)               acc_q  <= 1'b1;
         else if (stat_we && wdata[ST_ACC])     acc_q  <= 1'b0;
         if (launch_try && prot_e)              prot_q <= 1'b1;
         else if (stat_we && wdata[ST_PROT])    prot_q <= 1'b0;
      end
   end

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arr_start |=> !arr_start);
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arr_start |-> busy);
   p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && arr_done && !arr_start) |=> !busy);
   p_err_nostart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(acc_q) || $rose(prot_q)) |-> !arr_start);
endmodule

// File: rtl/idx_flash_launcher.sv
module idx_flash_launcher
   import fcl_pkg::*;
#(
   parameter int          IDX_W       = 3,
   parameter int          DIV_W       = 8,
   parameter int          SECT_BYTES  = 256,
   parameter int          SECT_COUNT  = 32,
   parameter logic [23:0] DF_BASE     = 24'h004000,
   parameter bit          ALIGN_ERASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [15:0]       wr_data,
   input  logic [1:0]        rd_sel,
   output logic [15:0]       rd_data,
   output logic              arr_start,
   output logic              arr_erase,
   output logic [23:0]       arr_addr,
   output logic [15:0]       arr_wdata,
   input  logic              arr_done,
   output logic [DIV_W-1:0]  arr_div
);
   localparam int DF_BYTES = SECT_BYTES * SECT_COUNT;

   if (IDX_W < 2 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must be between 2 and 8");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must be between 1 and 16");
   end
   if (SECT_BYTES != (1 << $clog2(SECT_BYTES)) || SECT_BYTES < 2) begin : g_bad_sect
      $error("SECT_BYTES must be a power of two");
   end
   if (longint'(DF_BASE) + longint'(DF_BYTES) > (longint'(1) << 24)) begin : g_bad_win
      $error("data-flash window exceeds the address space");
   end

   logic [DIV_W-1:0]               div_q;
   logic [IDX_W-1:0]               idx_q;
   logic [NUM_SLOTS-1:0][15:0]     obj_q;
   logic [NUM_SLOTS-1:0]           mask_q;
   logic                           busy, acc_q, prot_q, clr_mask, acc_e, prot_e;
   arr_req_t                       req, req_q;
   logic [15:0]                    slot_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  div_q <= '0;
      else if (wr_en && wr_sel == REG_DIV && !busy) div_q <= wr_data[DIV_W-1:0];
   end

   cmd_obj_file #(.IDX_W(IDX_W)) u_obj (
      .clk(clk), .rst_n(rst_n),
      .idx_we(wr_en && wr_sel == REG_IDX),
      .data_we(wr_en && wr_sel == REG_DATA),
      .wdata(wr_data), .lock(busy), .clr_mask(clr_mask),
      .idx_q(idx_q), .obj_q(obj_q), .mask_q(mask_q)
   );

   cmd_check #(
      .SECT_BYTES(SECT_BYTES), .SECT_COUNT(SECT_COUNT),
      .DF_BASE(DF_BASE), .ALIGN_ERASE(ALIGN_ERASE)
   ) u_chk (
      .obj(obj_q), .mask(mask_q), .div_ok(div_q != '0),
      .acc_e(acc_e), .prot_e(prot_e), .req(req)
   );

   launch_ctrl u_ctl (
      .clk(clk), .rst_n(rst_n),
      .stat_we(wr_en && wr_sel == REG_STAT), .wdata(wr_data),
      .acc_e(acc_e), .prot_e(prot_e), .req(req), .arr_done(arr_done),
      .busy(busy), .acc_q(acc_q), .prot_q(prot_q), .clr_mask(clr_mask),
      .arr_start(arr_start), .req_q(req_q)
   );

   always_comb begin
      slot_rd = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (idx_q == IDX_W'(i)) slot_rd = obj_q[i];
   end

   always_comb begin
      unique case (rd_sel)
         REG_DIV:  rd_data = 16'(div_q);
         REG_IDX:  rd_data = 16'(idx_q);
         REG_DATA: rd_data = slot_rd;
         default:  rd_data = {8'h00, !busy, 1'b0, acc_q, prot_q, 4'h0};
      endcase
   end

   assign arr_erase = req_q.erase;
   assign arr_addr  = req_q.addr;
   assign arr_wdata = req_q.wdata;
   assign arr_div   = div_q;

   p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      arr_start |-> (arr_addr >= DF_BASE &&
                     {1'b0, arr_addr} < {1'b0, DF_BASE} + 25'(DF_BYTES)));
endmodule

// File: tb/sim_idx_flash_launcher.sv
`timescale 1ns/1ps
module sim_idx_flash_launcher;
   logic        clk = 0, rst_n = 0;
   logic        wr_en = 0;
   logic [1:0]  wr_sel = 0, rd_sel = 0;
   logic [15:0] wr_data = 0, rd_data;
   logic        arr_start, arr_erase, arr_done = 0;
   logic [23:0] arr_addr;
   logic [15:0] arr_wdata;
   logic [7:0]  arr_div;

   int total = 0, bad = 0;
   logic [40:0] exp_q[$];
   int cnt = 0;

   always #2.5 clk = ~clk;

   idx_flash_launcher u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .arr_start(arr_start), .arr_erase(arr_erase),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_done(arr_done), .arr_div(arr_div)
   );

   // array model: completion pulse a few cycles after each request
   always @(posedge clk) begin
      arr_done <= 1'b0;
      if (arr_start) cnt <= 4;
      else if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) arr_done <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected requests when the design issues one
   always @(negedge clk) begin
      if (rst_n && arr_start) begin
         if (exp_q.size() == 0) check("R4 unexpected start", 32'd1, 32'd0);
         else begin
            logic [40:0] e;
            e = exp_q.pop_front();
            check("R4/R12 op", {31'd0, arr_erase}, {31'd0, e[40]});
            check("R4/R12 addr", {8'd0, arr_addr}, {8'd0, e[39:16]});
            if (!e[40]) check("R4 data", {16'd0, arr_wdata}, {16'd0, e[15:0]});
         end
      end
   end

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] d);
      rd_sel = s; #1; d = rd_data;
   endtask

   task automatic load(input logic [15:0] w0, w1, w2, input int n);
      logic [15:0] w[3];
      w[0] = w0; w[1] = w1; w[2] = w2;
      for (int i = 0; i < n; i++) begin
         wr(2'd1, 16'(i));
         wr(2'd2, w[i]);
      end
   endtask

   task automatic wait_done();
      logic [15:0] v;
      for (int i = 0; i < 40; i++) begin
         rd(2'd3, v);
         if (v[7]) break;
         @(negedge clk);
      end
   endtask

   initial begin
      #100000;
      check("watchdog", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      rd(2'd3, v); check("R1 status", v, 16'h0080);
      rd(2'd1, v); check("R1 index", v, 16'h0000);
      check("R1 start", {31'd0, arr_start}, 32'd0);
      // R2
      wr(2'd1, 16'h0005); rd(2'd1, v); check("R2 saturate", v, 16'h0002);
      wr(2'd1, 16'h0001); rd(2'd1, v); check("R2 plain", v, 16'h0001);
      // R7: divider still zero
      load(16'h4000, 16'h4100, 16'h0000, 2);
      rd(2'd2, v); check("R3 readback", v, 16'h4100);
      wr(2'd3, 16'h0080); @(negedge clk);
      rd(2'd3, v); check("R7 acc flag", v, 16'h00A0);
      // R10 clear
      wr(2'd3, 16'h0020); rd(2'd3, v); check("R10 w1c", v, 16'h0080);
      wr(2'd0, 16'h0004);
      // R4/R12 erase, unaligned address aligned down
      load(16'h4000, 16'h4123, 16'h0000, 2);
      exp_q.push_back({1'b1, 24'h004100, 16'h0000});
      wr(2'd3, 16'h0080);
      rd(2'd3, v); check("R4 busy status", v, 16'h0000);
      // R5 lock
      wr(2'd1, 16'h0001); wr(2'd2, 16'h1234);
      rd(2'd2, v); check("R5 locked slot", v, 16'h4123);
      wait_done();
      rd(2'd3, v); check("R6 done", v, 16'h0080);
      // program
      load(16'h2000, 16'h4201, 16'hBEEF, 3);
      exp_q.push_back({1'b0, 24'h004201, 16'hBEEF});
      wr(2'd3, 16'h0080);
      wait_done();
      rd(2'd3, v); check("R6 done prog", v, 16'h0080);
      // R11 only slot 0 rewritten since launch
      load(16'h2000, 16'h0000, 16'h0000, 1);
      wr(2'd3, 16'h0080); @(negedge clk);
      rd(2'd3, v); check("R11 missing params", v, 16'h00A0);
      wr(2'd3, 16'h0020);
      // R8 bad code
      load(16'h7700, 16'h4000, 16'h0001, 3);
      wr(2'd3, 16'h0080); @(negedge clk);
      rd(2'd3, v); check("R8 bad code", v, 16'h00A0);
      wr(2'd3, 16'h0020);
      // R9 boundary: base + 8192 is outside
      load(16'h2000, 16'h6000, 16'h0055, 3);
      wr(2'd3, 16'h0080); @(negedge clk);
      rd(2'd3, v); check("R9 prot flag", v, 16'h0090);
      // R10 launch ignored while error pending
      load(16'h2000, 16'h5FFF, 16'h00AA, 3);
      wr(2'd3, 16'h0080); @(negedge clk);
      rd(2'd3, v); check("R10 ignored launch", v, 16'h0090);
      wr(2'd3, 16'h0010); rd(2'd3, v); check("R10 prot w1c", v, 16'h0080);
      // slots still recorded: last in-range address starts
      exp_q.push_back({1'b0, 24'h005FFF, 16'h00AA});
      wr(2'd3, 16'h0080);
      wait_done();
      rd(2'd3, v); check("R9 last address ok", v, 16'h0080);
      repeat (3) @(negedge clk);
      check("R4 queue drained", exp_q.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule